// File: doc/BRIEF.md
# HDLC transmit FIFO controller

This block is the transmit half of a B-channel HDLC engine. A host loads a 32-bit control word holding a command byte, a block length and a mode byte. It then pushes the bytes of one block, up to 32 of them, into a transmit FIFO. The block turns those bytes into a bit-serial stream, moving one bit on each cycle where a bit-enable strobe is high. In HDLC mode it frames the data with 0x7E flags, inserts a zero after five consecutive ones, and appends an inverted CRC-16 check sequence. In transparent mode it sends the bytes unchanged.

Long frames are sent as a chain of blocks. A block becomes eligible to send once as many bytes as its length field asks for have been pushed. When the serializer takes the last byte of a block, a pool-ready status bit tells the host to load the next block. An end-of-frame command bit on the final block makes the block close the frame. If a non-final block drains and no successor has been loaded by the next byte boundary, an underrun status bit is raised. The line is then held at ones until the host pulses the transmitter reset and reloads the frame from its start.

Top module: `hdlc_tx_fifo`

## Requirements
- R1: A control write (`wr_sel`=1) takes the command from byte lane 0, the block length from bits 13:8 and the mode from byte lane 2. Each lane is written only when its `wr_be` bit is set, so the same word can be written as one access or as separate byte accesses.
- R2: A length field of 0 stands for a full block of 32 bytes. Any other value is the exact byte count of the block. FIFO pushes beyond 32 held bytes are dropped.
- R3: With mode bit 0 set, the idle line carries continuous 0x7E flags. A frame consists of a flag, the data bytes LSB first, the 16-bit check sequence and a closing flag. The check sequence is the complement of CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, computed over the data bits and sent low byte first, LSB first.
- R4: Inside a frame, including the check sequence, a 0 is sent after every run of five 1 bits. Flags are never stuffed.
- R5: A frame closes only after a block loaded with command bit 0 set. A block without that bit is followed, with no gap, by the next loaded block of the same frame.
- R6: With mode bit 1 set and bit 0 clear, block bytes are sent raw, LSB first, with no flags and no check sequence, even when command bit 0 is set. When no block is ready, the line idles at 1.
- R7: Status bit 7 (pool ready) is set in the cycle after the serializer takes the last byte of a block.
- R8: Status bit 6 (underrun) is set when an HDLC frame needs a byte at a byte boundary, the last block was not final and no new block is ready. From then on the line carries ones until a transmitter reset.
- R9: A command write with bit 7 set is a transmitter reset. It empties the FIFO, drops any pending block and restarts the serializer at a byte boundary in the newly written mode. The next loaded frame is then sent in full.
- R10: A cycle with `stat_rd` high clears both status bits, unless an event sets a bit in that same cycle; the newly set bit then remains. `irq` is high whenever a status bit is set.
- R11: `txd` changes only after a cycle with `bit_en` high.
- R12: With neither mode bit 0 nor mode bit 1 set, the line idles at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 1 | 0: push byte `wr_data[7:0]` into the FIFO, 1: control word write |
| wr_be | input | 4 | Byte enables for control writes |
| wr_data | input | 32 | Write data |
| stat_rd | input | 1 | Status read strobe; clears the status bits |
| stat_q | output | 8 | Status: bit 7 pool ready, bit 6 underrun, other bits zero |
| irq | output | 1 | High while any status bit is set |
| bit_en | input | 1 | Serial bit strobe |
| txd | output | 1 | Serial transmit data |

## Verification
A status read and a pool-ready event can fall in the same cycle. The bench provokes this in transparent mode, where the eighth strobe after a reset pops the only byte of a one-byte block. It drives `stat_rd` high in exactly that strobe cycle and expects bit 7 to survive. A plain read afterwards must then leave the status at zero. Every serial stream, including a two-block frame whose second block is loaded only after pool-ready, is compared bit by bit against a frame that the bench builds itself, with its own stuffing and CRC.

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [3:0]  wr_be,
  input  logic [31:0] wr_data,
  input  logic        stat_rd,
  output logic [7:0]  stat_q,
  output logic        irq,
  input  logic        bit_en,
  output logic        txd
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [7:0] FLAG = 8'h7E;
  typedef enum logic [2:0] {K_OFF, K_FLAG, K_DATA, K_FCS, K_TRANS, K_ABORT} kind_t;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] fill, rem, len_q;
  logic [7:0]    mode_q, shreg, fcs_hi, byte_nx;
  logic          xme_q, armed, blk_valid, blk_xme, last_final;
  logic          fcs_first, txd_q, xpr, xdu, pop_sel;
  logic [2:0]    bitcnt, ones;
  logic [15:0]   crc, crc_nx;
  kind_t         kind, kind_nx;

  wire ctl_wr  = wr_en && wr_sel;
  wire cmd_wr  = ctl_wr && wr_be[0];
  wire xrs     = cmd_wr && wr_data[7];
  wire arm     = cmd_wr && !wr_data[7];
  wire [7:0] mode_nx = (ctl_wr && wr_be[2]) ? wr_data[23:16] : mode_q;
  wire [CW-1:0] len_eff = (len_q == '0) ? CW'(DEPTH) : len_q;
  wire push     = wr_en && !wr_sel && (fill != CW'(DEPTH));
  wire stuff    = (ones == 3'd5);
  wire byte_end = bit_en && !xrs && !stuff && (bitcnt == 3'd7);
  wire popd     = byte_end && pop_sel;
  wire set_xpr  = popd && (rem == CW'(1));
  wire set_xdu  = byte_end && (kind == K_DATA) && !blk_valid && !last_final;

  assign crc_nx = {1'b0, crc[15:1]} ^ ((crc[0] ^ shreg[0]) ? 16'h8408 : 16'h0000);
  assign stat_q = {xpr, xdu, 6'b0};
  assign irq    = xpr | xdu;
  assign txd    = txd_q;

  always_comb begin
    pop_sel = 1'b0;
    kind_nx = kind;
    byte_nx = 8'hFF;
    case (kind)
      K_DATA:
        if (blk_valid) begin
          pop_sel = 1'b1; byte_nx = mem[rptr];
        end else if (last_final) begin
          kind_nx = K_FCS; byte_nx = ~crc_nx[7:0];
        end else kind_nx = K_ABORT;
      K_FCS:
        if (fcs_first) byte_nx = fcs_hi;
        else begin kind_nx = K_FLAG; byte_nx = FLAG; end
      K_ABORT: kind_nx = K_ABORT;
      default:
        if (mode_q[0]) begin
          if (blk_valid) begin pop_sel = 1'b1; kind_nx = K_DATA; byte_nx = mem[rptr]; end
          else begin kind_nx = K_FLAG; byte_nx = FLAG; end
        end else if (mode_q[1]) begin
          kind_nx = K_TRANS;
          if (blk_valid) begin pop_sel = 1'b1; byte_nx = mem[rptr]; end
        end else kind_nx = K_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0; len_q <= '0;
    end else begin
      if (ctl_wr && wr_be[2]) mode_q <= wr_data[23:16];
      if (ctl_wr && wr_be[1]) len_q <= wr_data[8 +: CW];
    end

  always_ff @(posedge clk)
    if (push) mem[wptr] <= wr_data[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; fill <= '0; rem <= '0;
      xme_q <= 1'b0; armed <= 1'b0; blk_valid <= 1'b0; blk_xme <= 1'b0; last_final <= 1'b0;
    end else if (xrs) begin
      wptr <= '0; rptr <= '0; fill <= '0;
      armed <= 1'b0; blk_valid <= 1'b0; last_final <= 1'b0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      fill <= fill + CW'(push) - CW'(popd);
      if (arm) begin
        armed <= 1'b1; xme_q <= wr_data[0];
      end else if (armed && !blk_valid && fill == len_eff) begin
        blk_valid <= 1'b1; rem <= len_eff; blk_xme <= xme_q; armed <= 1'b0;
      end
      if (popd) begin
        rptr <= rptr + AW'(1);
        rem  <= rem - CW'(1);
        if (rem == CW'(1)) begin
          blk_valid <= 1'b0; last_final <= blk_xme;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      kind <= K_OFF; shreg <= 8'hFF; bitcnt <= '0; ones <= '0;
      crc <= 16'hFFFF; fcs_hi <= '0; fcs_first <= 1'b0; txd_q <= 1'b1;
    end else if (xrs) begin
      kind  <= mode_nx[0] ? K_FLAG : (mode_nx[1] ? K_TRANS : K_OFF);
      shreg <= mode_nx[0] ? FLAG : 8'hFF;
      bitcnt <= '0; ones <= '0; fcs_first <= 1'b0;
    end else if (bit_en) begin
      if (stuff) begin
        txd_q <= 1'b0; ones <= '0;
      end else begin
        txd_q <= shreg[0];
        ones  <= (shreg[0] && (kind == K_DATA || kind == K_FCS)) ? ones + 3'd1 : 3'd0;
        if (kind == K_DATA) crc <= crc_nx;
        if (bitcnt == 3'd7) begin
          shreg <= byte_nx; kind <= kind_nx; bitcnt <= '0;
          if (kind_nx == K_DATA && kind != K_DATA) crc <= 16'hFFFF;
          if (kind == K_DATA && kind_nx == K_FCS) begin
            fcs_hi <= ~crc_nx[15:8]; fcs_first <= 1'b1;
          end else if (kind == K_FCS) fcs_first <= 1'b0;
        end else begin
          shreg <= {1'b1, shreg[7:1]}; bitcnt <= bitcnt + 3'd1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xpr <= 1'b0; xdu <= 1'b0;
    end else begin
      xpr <= set_xpr | (xpr & !stat_rd);
      xdu <= set_xdu | (xdu & !stat_rd);
    end

  a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n) fill <= CW'(DEPTH));
  a_r4_zero_after_five: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !xrs && ones == 3'd5 |=> !txd);
  a_r7_pool_ready: assert property (@(posedge clk) disable iff (!rst_n) set_xpr |=> stat_q[7]);
  a_r8_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_ABORT && bit_en && !xrs |=> txd);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !set_xpr && !set_xdu |=> stat_q == 8'h00);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n) !bit_en |=> $stable(txd));
  a_r12_off_ones: assert property (@(posedge clk) disable iff (!rst_n)
    kind == K_OFF && bit_en && !xrs |=> txd);
endmodule

// File: tb/hdlc_tx_fifo_bench.sv
module hdlc_tx_fifo_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0, stat_rd = 1'b0, bit_en = 1'b0;
  logic [3:0] wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [7:0] stat_q;
  logic irq, txd;

  hdlc_tx_fifo u_hdlc_tx_fifo (.clk, .rst_n, .wr_en, .wr_sel, .wr_be, .wr_data,
    .stat_rd, .stat_q, .irq, .bit_en, .txd);

  always #5 clk = ~clk;

  // {mode, len[5:0], seed, step, end-of-frame, expected status}
  localparam logic [38:0] VEC [0:5] = '{
    {8'h01, 6'd1,  8'h55, 8'h00, 1'b1, 8'h80},
    {8'h01, 6'd3,  8'hFF, 8'h00, 1'b1, 8'h80},
    {8'h01, 6'd0,  8'h00, 8'h07, 1'b1, 8'h80},
    {8'h02, 6'd4,  8'h3C, 8'h11, 1'b1, 8'h80},
    {8'h02, 6'd2,  8'h81, 8'h01, 1'b0, 8'h80},
    {8'h01, 6'd5,  8'hF8, 8'h03, 1'b1, 8'h80}
  };

  int checks = 0, errors = 0, exp_n = 0, fr_n = 0, m_ones = 0;
  bit done = 1'b0;
  logic exp_b [0:1023];
  logic got_b [0:1023];
  logic [7:0] fr [0:63];
  logic [15:0] m_crc;

  function automatic string row_tag(int i);
    case (i)
      1: return "R4";
      2: return "R2";
      3, 4: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic check(bit ok, string tag, int got, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [3:0] be, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic stat_clear();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic one_bit(int idx);
    @(negedge clk); bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    got_b[idx] = txd;
  endtask

  task automatic put(logic b);
    exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic put_raw(logic [7:0] v);
    for (int i = 0; i < 8; i++) put(v[i]);
  endtask

  task automatic put_st(logic b);
    put(b);
    if (b) begin
      m_ones++;
      if (m_ones == 5) begin put(1'b0); m_ones = 0; end
    end else m_ones = 0;
  endtask

  task automatic build(bit hdlc);
    logic [15:0] fcs;
    exp_n = 0;
    if (hdlc) begin
      put_raw(8'h7E); m_ones = 0; m_crc = 16'hFFFF;
      for (int k = 0; k < fr_n; k++)
        for (int i = 0; i < 8; i++) begin
          logic fb;
          fb = m_crc[0] ^ fr[k][i];
          m_crc = m_crc >> 1;
          if (fb) m_crc = m_crc ^ 16'h8408;
          put_st(fr[k][i]);
        end
      fcs = ~m_crc;
      for (int i = 0; i < 16; i++) put_st(fcs[i]);
      put_raw(8'h7E); put_raw(8'h7E);
    end else begin
      put_raw(8'hFF);
      for (int k = 0; k < fr_n; k++) put_raw(fr[k]);
      put_raw(8'hFF);
    end
  endtask

  task automatic load(logic [7:0] md, int len, logic [7:0] seed, logic [7:0] step, logic xme);
    wr(1'b1, 4'b0111, {8'h00, md, 2'b00, 6'(len), 8'h80});
    stat_clear();
    wr(1'b1, 4'b0111, {8'h00, md, 2'b00, 6'(len), 7'h00, xme});
    fr_n = (len == 0) ? 32 : len;
    for (int i = 0; i < fr_n; i++) begin
      fr[i] = 8'(seed + i * step);
      wr(1'b0, 4'b0001, {24'h0, fr[i]});
    end
    idle(2);
  endtask

  task automatic compare(string tag);
    int bad = -1;
    for (int i = 0; i < exp_n; i++) if (bad < 0 && got_b[i] !== exp_b[i]) bad = i;
    check(bad < 0, tag, bad < 0 ? 0 : int'(got_b[bad]) + 16 * bad,
          bad < 0 ? 0 : int'(exp_b[bad]) + 16 * bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3); rst_n = 1'b1; idle(2);
    check(stat_q == 8'h00, "R10 reset status", stat_q, 0);
    check(irq == 1'b0, "R10 reset irq", irq, 0);
    check(txd == 1'b1, "R12 reset line", txd, 1);

    for (int r = 0; r < 6; r++) begin
      load(VEC[r][38:31], int'(VEC[r][30:25]), VEC[r][24:17], VEC[r][16:9], VEC[r][8]);
      build(VEC[r][31]);
      for (int i = 0; i < exp_n; i++) one_bit(i);
      compare(row_tag(r));
      check(stat_q == VEC[r][7:0], "R7 pool ready", stat_q, VEC[r][7:0]);
    end

    // R1: separate byte-lane writes build a transparent 3-byte block
    wr(1'b1, 4'b0100, 32'h0002_0000);
    wr(1'b1, 4'b0001, 32'h0000_0080);
    stat_clear();
    wr(1'b1, 4'b0010, 32'h0000_0300);
    wr(1'b1, 4'b0001, 32'h0000_0000);
    fr_n = 3;
    for (int i = 0; i < 3; i++) begin
      fr[i] = 8'hA0 + 8'(i);
      wr(1'b0, 4'b0001, {24'h0, fr[i]});
    end
    idle(2); build(1'b0);
    for (int i = 0; i < exp_n; i++) one_bit(i);
    compare("R1");

    // R5: 32-byte block without end-of-frame, then final 3-byte block after pool ready
    begin
      bit loaded = 1'b0;
      load(8'h01, 0, 8'h10, 8'h05, 1'b0);
      fr_n = 35;
      for (int i = 32; i < 35; i++) fr[i] = 8'hE0 + 8'(i);
      build(1'b1);
      for (int i = 0; i < exp_n; i++) begin
        one_bit(i);
        if (stat_q[7] && !loaded) begin
          loaded = 1'b1;
          stat_clear();
          wr(1'b1, 4'b0011, 32'h0000_0301);
          for (int k = 32; k < 35; k++) wr(1'b0, 4'b0001, {24'h0, fr[k]});
          idle(2);
        end
      end
      compare("R5");
      check(stat_q[6] == 1'b0, "R5 no underrun", stat_q, 8'h80);
    end

    // R8: non-final block drains with nothing behind it
    load(8'h01, 2, 8'h12, 8'h22, 1'b0);
    for (int i = 0; i < 24; i++) one_bit(i);
    check(stat_q == 8'hC0, "R8 underrun flag", stat_q, 8'hC0);
    check(irq == 1'b1, "R10 irq on status", irq, 1);
    begin
      int zeros = 0;
      for (int i = 0; i < 16; i++) begin one_bit(i); if (!got_b[i]) zeros++; end
      check(zeros == 0, "R8 ones after underrun", zeros, 0);
    end

    // R9: reset and reload restarts cleanly
    load(8'h01, 2, 8'h12, 8'h22, 1'b1);
    check(stat_q == 8'h00, "R9 clean after restart", stat_q, 0);
    build(1'b1);
    for (int i = 0; i < exp_n; i++) one_bit(i);
    compare("R9");

    // R11: first flag bit is 0 and must hold while the strobe is low
    wr(1'b1, 4'b0101, 32'h0001_0080);
    one_bit(0);
    idle(20);
    check(txd == 1'b0, "R11 hold", txd, 0);

    // R12: no mode selected
    wr(1'b1, 4'b0101, 32'h0000_0080);
    begin
      int zeros = 0;
      for (int i = 0; i < 16; i++) begin one_bit(i); if (!got_b[i]) zeros++; end
      check(zeros == 0, "R12 off line", zeros, 0);
    end

    // R10 with R7: read strobe in the same cycle as the pop of a 1-byte block
    load(8'h02, 1, 8'h5A, 8'h00, 1'b0);
    for (int i = 0; i < 7; i++) one_bit(i);
    check(stat_q == 8'h00, "R7 not before pop", stat_q, 0);
    @(negedge clk); bit_en = 1'b1; stat_rd = 1'b1;
    @(negedge clk); bit_en = 1'b0; stat_rd = 1'b0;
    check(stat_q == 8'h80, "R10 set wins over read", stat_q, 8'h80);
    stat_clear();
    check(stat_q == 8'h00, "R10 read clears", stat_q, 0);

    // R2: 33rd push is dropped; a full block still sends exactly 32 bytes
    load(8'h02, 0, 8'h01, 8'h01, 1'b0);
    wr(1'b0, 4'b0001, 32'h0000_0033);
    idle(2); build(1'b0);
    for (int i = 0; i < exp_n; i++) one_bit(i);
    compare("R2 overflow drop");

    finish_run();
  end
endmodule